// File: doc/BRIEF.md
# Transceiver Configuration Port Bridge

This block lets a 32-bit memory-mapped register bus reach the dynamic reconfiguration ports of a group of serial transceiver channels and of their shared PLL. Each reconfiguration port is a 16-bit data, address-based port. A transaction starts with a one-cycle enable strobe, together with a write-enable for writes. It ends when the port returns a one-cycle ready pulse; for reads, the data comes with that pulse.

Software first writes a control word. The word selects exactly one target, as a one-hot vector over the lane channels and the PLL channel, and sets a global access-enable bit. Bus accesses to an address window then become reconfiguration transactions on that target. The bridge holds the bus response until the target reports ready. It gives up after a fixed number of cycles. It drives a busy flag for as long as a transaction is open.

The bus handshake works as follows. The master raises `bus_req` with address, direction and data, and holds them until `bus_ack` pulses for one cycle. It then drops `bus_req` before the next rising edge. Read data is valid in the cycle `bus_ack` is high.

Top module: `drp_bridge`

## Requirements
- R1: After reset, `bus_ack`, `drp_busy` and every `drp_en` bit are low, and a read of the control word returns 0.
- R2: The control word sits at byte address 0x000. Bits [3:0] select lane channels 0 to 3 and bit 4 selects the PLL channel. Bit 16 enables access. Bit 20 reads back the busy flag and ignores writes. Every other bit reads 0. Control accesses are acknowledged in the cycle after the request is accepted.
- R3: Reconfiguration address A is reached at byte address 0x800 + 4·A, for A = 0 to 511. `drp_addr` carries A, and `drp_di` carries bits [15:0] of the bus write data.
- R4: Each window transaction raises exactly one `drp_en` bit, that of the selected channel, for exactly one cycle. `drp_we` is high with it for writes and low for reads.
- R5: The bus acknowledgement waits for the selected channel's ready pulse and arrives one cycle after it. A read returns the channel's 16-bit data in bits [15:0] with bits [31:16] zero. A write returns 0. `bus_ack` is high for one cycle.
- R6: `drp_busy` rises with the `drp_en` strobe, stays high while the transaction is open, and is low in the cycle `bus_ack` reports the result.
- R7: A window access is acknowledged in the cycle after acceptance, with no strobe, when access is disabled or the select field is zero or has more than one bit set. Such a read returns 0 and such a write changes no target register. An access outside both the control word and the window behaves the same way.
- R8: If no ready arrives within 256 cycles of the strobe, the transaction is abandoned and `drp_busy` clears. A read then returns 0x0000FFFF and a write returns 0. The acknowledgement comes 257 cycles after acceptance.
- R9: Writing a new one-hot select with the enable bit set moves access to that target without first writing zero. Writing 0 to the control word disables access.
- R10: A window read after a window write to the same address on the same target returns the written 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address relative to the block base |
| bus_wdata | input | 32 | Bus write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| drp_busy | output | 1 | A reconfiguration transaction is open |
| drp_en | output | NUM_LANES+NUM_PLLS | Per-channel enable strobe, lanes first, PLL last |
| drp_we | output | 1 | Write-enable qualifying the strobe |
| drp_addr | output | DRP_AW | Register address inside the target |
| drp_di | output | DRP_DW | Write data to the target |
| drp_do | input | (NUM_LANES+NUM_PLLS)*DRP_DW | Per-channel read data, channel c at bits [c*DRP_DW +: DRP_DW] |
| drp_rdy | input | NUM_LANES+NUM_PLLS | Per-channel ready pulse |

## Verification
Some properties hold on every cycle, and the assertions check those. At most one enable strobe is active, and it lasts one cycle. Busy covers the strobe and is clear whenever a result is acknowledged. A refused access is acknowledged next cycle with zero and no strobe. An abandoned read yields 0xFFFF, and a window result never has upper bits set. The bench's scenarios cover the rest. They show that the strobe lands on the channel the software chose, at the address the window offset encodes. They show that data written to one target comes back from that target and not from another, and that retargeting needs no disable. They also confirm the exact acknowledgement latency for several ready delays and for the 256-cycle abort.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

  // control word field positions (software visible)
  localparam int CTL_EN_BIT   = 16;
  localparam int CTL_BUSY_BIT = 20;

  // true when exactly one bit of v is set
  function automatic logic single_hot(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/drp_bridge_ctl.sv
module drp_bridge_ctl
  import drp_bridge_pkg::*;
#(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [NCH-1:0] sel_in,
  input  logic           en_in,
  input  logic           busy,
  output logic [NCH-1:0] sel,
  output logic           en,
  output logic           ok,
  output logic [31:0]    word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
      en  <= 1'b0;
    end else if (wr) begin
      sel <= sel_in;
      en  <= en_in;
    end
  end

  assign ok = en && single_hot(32'(sel));

  always_comb begin
    word               = '0;
    word[NCH-1:0]      = sel;
    word[CTL_EN_BIT]   = en;
    word[CTL_BUSY_BIT] = busy;
  end

endmodule

// File: rtl/drp_bridge_mux.sv
module drp_bridge_mux #(
  parameter int NCH = 5,
  parameter int DW  = 16
) (
  input  logic [NCH*DW-1:0] drp_do,
  input  logic [NCH-1:0]    drp_rdy,
  input  logic [NCH-1:0]    tgt,
  output logic [DW-1:0]     do_sel,
  output logic              rdy_sel
);

  logic [DW-1:0] masked [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_mask
    assign masked[c] = tgt[c] ? drp_do[c*DW +: DW] : '0;
  end

  always_comb begin
    do_sel = '0;
    for (int c = 0; c < NCH; c++) do_sel = do_sel | masked[c];
  end

  assign rdy_sel = |(drp_rdy & tgt);

endmodule

// File: rtl/drp_bridge_seq.sv
module drp_bridge_seq
  import drp_bridge_pkg::*;
#(
  parameter int NCH     = 5,
  parameter int AW      = 9,
  parameter int DW      = 16,
  parameter int TIMEOUT = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_we,
  input  logic [AW-1:0]  start_addr,
  input  logic [DW-1:0]  start_data,
  input  logic [NCH-1:0] start_tgt,
  input  logic           rdy_sel,
  input  logic [DW-1:0]  do_sel,
  output logic [NCH-1:0] drp_en,
  output logic           drp_we,
  output logic [AW-1:0]  drp_addr,
  output logic [DW-1:0]  drp_di,
  output logic [NCH-1:0] tgt,
  output logic           busy,
  output logic           wait_st,
  output logic           done,
  output logic [DW-1:0]  done_data,
  output logic           timeout_hit
);

  localparam int          CW   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [NCH-1:0] en_q;
  logic           last_wait;

  assign wait_st     = (state_q == SEQ_WAIT);
  assign last_wait   = (cnt_q == LAST);
  assign done        = wait_st && (rdy_sel || last_wait);
  assign timeout_hit = wait_st && !rdy_sel && last_wait;
  assign done_data   = drp_we ? '0 : (rdy_sel ? do_sel : '1);
  assign busy        = wait_st;
  assign drp_en      = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      en_q     <= '0;
      drp_we   <= 1'b0;
      drp_addr <= '0;
      drp_di   <= '0;
      tgt      <= '0;
    end else begin
      en_q <= '0;
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q  <= SEQ_WAIT;
          cnt_q    <= '0;
          en_q     <= start_tgt;
          tgt      <= start_tgt;
          drp_we   <= start_we;
          drp_addr <= start_addr;
          drp_di   <= start_data;
        end
        SEQ_WAIT: begin
          if (done) state_q <= SEQ_IDLE;
          else      cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
  import drp_bridge_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int NUM_PLLS  = 1,
  parameter int DRP_AW    = 9,
  parameter int DRP_DW    = 16,
  parameter int BUS_AW    = 16,
  parameter int TIMEOUT   = 256,
  parameter int WIN_BASE  = 32'h800,
  parameter int CTL_ADDR  = 0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bus_req,
  input  logic                                  bus_we,
  input  logic [BUS_AW-1:0]                     bus_addr,
  input  logic [31:0]                           bus_wdata,
  output logic                                  bus_ack,
  output logic [31:0]                           bus_rdata,
  output logic                                  drp_busy,
  output logic [NUM_LANES+NUM_PLLS-1:0]         drp_en,
  output logic                                  drp_we,
  output logic [DRP_AW-1:0]                     drp_addr,
  output logic [DRP_DW-1:0]                     drp_di,
  input  logic [(NUM_LANES+NUM_PLLS)*DRP_DW-1:0] drp_do,
  input  logic [NUM_LANES+NUM_PLLS-1:0]         drp_rdy
);

  localparam int          NCH    = NUM_LANES + NUM_PLLS;
  localparam logic [31:0] WIN_LO = 32'(WIN_BASE);
  localparam logic [31:0] WIN_HI = WIN_LO + 32'(4 << DRP_AW);

  function automatic logic in_window(input logic [BUS_AW-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    return (w >= WIN_LO) && (w < WIN_HI);
  endfunction

  function automatic logic [DRP_AW-1:0] win_index(input logic [BUS_AW-1:0] a);
    logic [31:0] w;
    w = 32'(a) - WIN_LO;
    return DRP_AW'(w >> 2);
  endfunction

  logic              ack_q;
  logic [31:0]       rdata_q;
  logic [NCH-1:0]    ctl_sel;
  logic              ctl_en, ctl_ok;
  logic [31:0]       ctl_word;
  logic [NCH-1:0]    tgt;
  logic              seq_busy, seq_wait, seq_done, seq_timeout;
  logic [DRP_DW-1:0] seq_data, mux_do;
  logic              mux_rdy;

  // named events, also observed by the bound checker
  logic hit_ctl, hit_win, accept, start_drp, blocked_acc, ctl_wr;
  assign hit_ctl     = (bus_addr == BUS_AW'(CTL_ADDR));
  assign hit_win     = in_window(bus_addr);
  assign accept      = bus_req && !seq_busy && !ack_q;
  assign start_drp   = accept && hit_win && ctl_ok;
  assign blocked_acc = accept && !start_drp && !hit_ctl;
  assign ctl_wr      = accept && hit_ctl && bus_we;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:17];

  drp_bridge_ctl #(.NCH(NCH)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctl_wr),
    .sel_in (bus_wdata[NCH-1:0]),
    .en_in  (bus_wdata[CTL_EN_BIT]),
    .busy   (seq_busy),
    .sel    (ctl_sel),
    .en     (ctl_en),
    .ok     (ctl_ok),
    .word   (ctl_word)
  );

  drp_bridge_mux #(.NCH(NCH), .DW(DRP_DW)) u_mux (
    .drp_do  (drp_do),
    .drp_rdy (drp_rdy),
    .tgt     (tgt),
    .do_sel  (mux_do),
    .rdy_sel (mux_rdy)
  );

  drp_bridge_seq #(.NCH(NCH), .AW(DRP_AW), .DW(DRP_DW), .TIMEOUT(TIMEOUT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_drp),
    .start_we    (bus_we),
    .start_addr  (win_index(bus_addr)),
    .start_data  (bus_wdata[DRP_DW-1:0]),
    .start_tgt   (ctl_sel),
    .rdy_sel     (mux_rdy),
    .do_sel      (mux_do),
    .drp_en      (drp_en),
    .drp_we      (drp_we),
    .drp_addr    (drp_addr),
    .drp_di      (drp_di),
    .tgt         (tgt),
    .busy        (seq_busy),
    .wait_st     (seq_wait),
    .done        (seq_done),
    .done_data   (seq_data),
    .timeout_hit (seq_timeout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (seq_done) begin
        ack_q   <= 1'b1;
        rdata_q <= 32'(seq_data);
      end else if (accept && !start_drp) begin
        ack_q   <= 1'b1;
        rdata_q <= (hit_ctl && !bus_we) ? ctl_word : '0;
      end
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign drp_busy  = seq_busy;

endmodule

// File: rtl/drp_bridge_chk.sv
module drp_bridge_chk #(
  parameter int NCH = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_ack,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] drp_en,
  input logic           drp_busy,
  input logic           drp_we,
  input logic           blocked_acc,
  input logic           seq_wait,
  input logic           seq_timeout
);

  assert_en_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drp_en));

  assert_en_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|drp_en) |=> !(|drp_en));

  assert_busy_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|drp_en) |-> drp_busy);

  assert_busy_rise_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drp_busy) |-> (|drp_en));

  assert_ack_frees_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> !drp_busy);

  assert_ack_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_window_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && $past(seq_wait)) |-> (bus_rdata[31:16] == 16'h0));

  assert_blocked_immediate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_acc |=> (bus_ack && !(|drp_en) && bus_rdata == 32'h0));

  assert_timeout_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_timeout && !drp_we) |=> (bus_ack && !drp_busy && bus_rdata == 32'h0000FFFF));

endmodule

bind drp_bridge drp_bridge_chk #(.NCH(NUM_LANES + NUM_PLLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_ack     (bus_ack),
  .bus_rdata   (bus_rdata),
  .drp_en      (drp_en),
  .drp_busy    (drp_busy),
  .drp_we      (drp_we),
  .blocked_acc (blocked_acc),
  .seq_wait    (seq_wait),
  .seq_timeout (seq_timeout)
);

// File: tb/tb_drp_bridge.sv
module tb_drp_bridge;

  localparam int NCH = 5;
  localparam int AWD = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_ack, drp_busy, drp_we;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    drp_en, drp_rdy;
  logic [AWD-1:0]    drp_addr;
  logic [15:0]       drp_di;
  logic [NCH*16-1:0] drp_do;

  always #5 clk = ~clk;

  drp_bridge dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .drp_busy(drp_busy), .drp_en(drp_en),
    .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
    .drp_do(drp_do), .drp_rdy(drp_rdy)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // ---------------- target models: register files with variable latency
  function automatic logic [15:0] init_val(input int c, input int a);
    return 16'(c * 4096 + a * 3 + 7);
  endfunction

  int          lat  [NCH];
  bit          mute [NCH];
  logic [15:0] mem  [NCH][512];
  logic [15:0] rdq  [NCH];
  logic [15:0] do_r [NCH];
  int          pend [NCH];

  always_comb for (int c = 0; c < NCH; c++) drp_do[c*16 +: 16] = do_r[c];

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        for (int a = 0; a < 512; a++) mem[c][a] <= init_val(c, a);
        pend[c] <= 0;
        drp_rdy[c] <= 1'b0;
        do_r[c] <= '0;
        rdq[c] <= '0;
      end else begin
        drp_rdy[c] <= 1'b0;
        if (pend[c] > 0) begin
          pend[c] <= pend[c] - 1;
          if (pend[c] == 1) begin
            drp_rdy[c] <= 1'b1;
            do_r[c] <= rdq[c];
          end
        end
        if (drp_en[c]) begin
          if (drp_we) mem[c][drp_addr] <= drp_di;
          rdq[c] <= mem[c][drp_addr];
          if (!mute[c]) pend[c] <= lat[c];
        end
      end
    end
  end

  // ---------------- per-cycle reference model
  logic [NCH-1:0] m_sel = '0;
  bit             m_en = 0;
  bit             outst = 0;
  bit             cur_we = 0;
  logic [AWD-1:0] exp_a = '0;
  logic [15:0]    cur_wd = '0;

  function automatic bit m_ok();
    return m_en && ($countones(m_sel) == 1);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (|drp_en) begin
        outst = 1;
        check("R4 strobe channel", 32'(drp_en), m_ok() ? 32'(m_sel) : 32'h0);
        check("R4 write enable", 32'(drp_we), 32'(cur_we));
        check("R3 drp address", 32'(drp_addr), 32'(exp_a));
        if (cur_we) check("R3 drp write data", 32'(drp_di), 32'(cur_wd));
      end
      if (bus_ack) outst = 0;
      check("R6 busy per cycle", 32'(drp_busy), 32'(outst));
    end
  end

  // ---------------- bus tasks
  task automatic access(input bit we, input logic [15:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int n);
    @(negedge clk);
    cur_we = we; cur_wd = wd[15:0];
    bus_we = we; bus_addr = addr; bus_wdata = wd; bus_req = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!bus_ack && n < 2000);
    rd = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic ctl_write(input logic [31:0] v);
    logic [31:0] rd; int n;
    access(1'b1, 16'h000, v, rd, n);
    check("R2 control write latency", 32'(n), 32'd1);
    m_sel = v[NCH-1:0];
    m_en  = v[16];
  endtask

  task automatic win(input bit we, input int a, input logic [31:0] wd,
                     input logic [31:0] exp_rd, input int exp_n, input string req);
    logic [31:0] rd; int n;
    exp_a = AWD'(a);
    access(we, 16'(32'h800 + 4 * a), wd, rd, n);
    check({req, " data"}, rd, exp_rd);
    check({req, " latency"}, 32'(n), 32'(exp_n));
  endtask

  // ---------------- watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd; int n;
    for (int c = 0; c < NCH; c++) begin lat[c] = 1 + c; mute[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ack in reset", 32'(bus_ack), 32'd0);
    check("R1 busy in reset", 32'(drp_busy), 32'd0);
    check("R1 strobe in reset", 32'(drp_en), 32'd0);
    rst_n = 1'b1;
    access(1'b0, 16'h000, 32'h0, rd, n);
    check("R1 control after reset", rd, 32'h0);

    // R2 layout, busy bit read-only
    ctl_write(32'h0011_0001);
    access(1'b0, 16'h000, 32'h0, rd, n);
    check("R2 control readback", rd, 32'h0001_0001);

    // R3/R5/R10 channel 0, latency 1
    win(1'b1, 5, 32'hABCD_1234, 32'h0, 1 + 3, "R5 write ack");
    win(1'b0, 5, 32'h0, 32'h0000_1234, 1 + 3, "R10 readback");
    lat[0] = 7;
    win(1'b0, 511, 32'h0, 32'(init_val(0, 511)), 7 + 3, "R3 top address");
    win(1'b0, 0, 32'h0, 32'(init_val(0, 0)), 7 + 3, "R5 read low address");

    // R9 retarget to PLL channel without disabling
    ctl_write(32'h0001_0010);
    win(1'b0, 5, 32'h0, 32'(init_val(4, 5)), 5 + 3, "R9 pll untouched");
    win(1'b1, 5, 32'hFFFF_5A5A, 32'h0, 5 + 3, "R5 pll write");
    win(1'b0, 5, 32'h0, 32'h0000_5A5A, 5 + 3, "R10 pll readback");
    ctl_write(32'h0001_0001);
    win(1'b0, 5, 32'h0, 32'h0000_1234, 7 + 3, "R9 back to lane0");

    // R7 multi-hot, empty select, disabled, stray address
    ctl_write(32'h0001_0003);
    win(1'b0, 5, 32'h0, 32'h0, 1, "R7 multi-hot read");
    win(1'b1, 5, 32'h0000_9999, 32'h0, 1, "R7 multi-hot write");
    ctl_write(32'h0001_0000);
    win(1'b0, 5, 32'h0, 32'h0, 1, "R7 empty select read");
    ctl_write(32'h0);
    access(1'b0, 16'h000, 32'h0, rd, n);
    check("R9 zero disables", rd, 32'h0);
    win(1'b1, 6, 32'h0000_7777, 32'h0, 1, "R7 disabled write");
    win(1'b0, 6, 32'h0, 32'h0, 1, "R7 disabled read");
    access(1'b0, 16'h400, 32'h0, rd, n);
    check("R7 stray address data", rd, 32'h0);
    check("R7 stray address latency", 32'(n), 32'd1);
    ctl_write(32'h0001_0001);
    win(1'b0, 5, 32'h0, 32'h0000_1234, 7 + 3, "R7 multi-hot write had no effect");
    win(1'b0, 6, 32'h0, 32'(init_val(0, 6)), 7 + 3, "R7 disabled write had no effect");

    // R8 timeout on channel 2
    mute[2] = 1;
    ctl_write(32'h0001_0004);
    win(1'b0, 9, 32'h0, 32'h0000_FFFF, 257, "R8 timeout read");
    check("R8 busy cleared", 32'(drp_busy), 32'd0);
    win(1'b1, 9, 32'h0000_4321, 32'h0, 257, "R8 timeout write");
    mute[2] = 0;
    repeat (4) @(posedge clk);
    win(1'b0, 9, 32'h0, 32'h0000_4321, 3 + 3, "R8 recovery read");
    lat[2] = 1;
    win(1'b0, 10, 32'h0, 32'(init_val(2, 10)), 1 + 3, "R5 lane2 read");

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule